// File: doc/BRIEF.md
# Configuration Wake-Up Sequencer

This block controls the last phase of bringing a programmable device out of configuration. A length counter counts configuration-clock strobes from the moment the init line is seen high. Configuration memory must also be reported full, and the count must equal a loaded length value. When both hold, a five-stage sticky shift register is started. Three events take their timing from programmable taps on that register: the open-drain done line stops pulling low, the user I/O pins become active, and the global set/reset of the storage elements is released.

A configuration option picks the strobe that advances stages 1 to 4: the configuration-clock strobe or a user-clock strobe. Stage 0 always advances on the configuration strobe. A second option makes stage 3 wait on the sensed state of the wire-ANDed done line, so that other devices on that line can hold back the whole group. If the user strobe is selected and it stops, the register stalls. Done can then already be released while the I/Os never come alive. All clocks are modelled as strobes into a single simulation clock domain. The open-drain pin is modelled as a pull-low enable and a separate sensed input.

Top module: `wake_sequencer`

## Requirements
- R1: While `init_hi` is low the length count is zero. While `init_hi` is high the count increases by one on each cycle with `cfg_stb` high, and it stops at `len_value` without passing it or wrapping.
- R2: Stage 0 (`stage_q[0]`) is set at the first clock edge at which `cfg_stb` is high, `mem_full` is high, and the count equals `len_value`. It is never set earlier.
- R3: Stages 1 to 4 advance only on the advance strobe: `usr_stb` when `use_user_clk`=1, and `cfg_stb` when it is 0. On such an edge, stage k is set if stage k-1 is set. Every stage, once set, stays set until reset.
- R4: Each of `done_tap`, `io_tap` and `gsr_tap` maps code 0 to stage 1, 1 to stage 2, 2 to stage 3 and 3 to stage 4. An event becomes active in the same cycle as its selected stage.
- R5: With taps done=0, io=1, gsr=2 and all strobes present, done is released first, the I/Os become active one cycle later, and set/reset is released one cycle after that.
- R6: With `sync_to_done`=1, stage 3 is set only on an advance edge at which stage 2 is set and `done_sense` is high. A done line held low stalls stages 3 and 4.
- R7: With `sync_to_done`=0, `done_sense` has no effect on the stage timing.
- R8: After reset `done_drive_low` is 1 and `io_active` and `gsr_released` are 0. Once an event becomes active it stays active until reset, even if `init_hi` or `mem_full` fall.
- R9: With `use_user_clk`=1 and no `usr_stb`, the register stops after stage 0. If exactly one user strobe follows, done is released (tap 0) and the I/Os stay inactive indefinitely.
- R10: After reset `stage_q` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_stb | input | 1 | Configuration-clock strobe |
| usr_stb | input | 1 | User start-up clock strobe |
| init_hi | input | 1 | Init line level; counting runs while high |
| mem_full | input | 1 | Configuration memory full flag |
| len_value | input | 24 | Loaded length count |
| use_user_clk | input | 1 | 1: stages 1 to 4 advance on `usr_stb` |
| sync_to_done | input | 1 | 1: stage 3 waits on `done_sense` |
| done_tap | input | 2 | Stage select for done release |
| io_tap | input | 2 | Stage select for I/O activation |
| gsr_tap | input | 2 | Stage select for set/reset release |
| done_sense | input | 1 | Sensed level of the wire-ANDed done line |
| done_drive_low | output | 1 | Pull-low enable of the open-drain done pin |
| io_active | output | 1 | User I/O enable |
| gsr_released | output | 1 | Global set/reset released |
| stage_q | output | 5 | Wake-up register stages 0 to 4 |

## Verification
Two events can become active in the same cycle. This happens when they share a tap, or when the done line is released in the same cycle as stage 2 arrives. A table vector gives done and I/O the same stage select. Another lets the external done hold end while stage 2 is waiting. In both, the cycle at which each output is first seen active is compared with the cycle derived from the length, the taps and the hold point. Coincident events must report identical cycles, and a stalled stage 3 must resume exactly one edge after the line is sensed high.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int STAGES     = 5;
  localparam int SYNC_STAGE = 3;

  typedef logic [1:0] tap_sel_t;

  // tap code n selects stage n+1
  function automatic logic [2:0] tap_to_stage(input tap_sel_t sel);
    return {1'b0, sel} + 3'd1;
  endfunction

  function automatic logic count_may_step(input logic [23:0] cnt,
                                          input logic [23:0] lim);
    return cnt < lim;
  endfunction
endpackage

// File: rtl/wake_len_counter.sv
module wake_len_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_hi,
  input  logic             cfg_stb,
  input  logic [CNT_W-1:0] len_value,
  output logic             count_match
);
  logic [CNT_W-1:0] cnt_q;
  logic             step_ok;

  assign step_ok     = (cnt_q < len_value);
  assign count_match = (cnt_q == len_value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (!init_hi)           cnt_q <= '0;
    else if (cfg_stb && step_ok) cnt_q <= cnt_q + 1'b1;
  end

  assert_clear_low_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_hi |=> cnt_q == '0);
  assert_no_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (init_hi && count_match) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/wake_stage_chain.sv
module wake_stage_chain
  import wake_pkg::*;
#(
  parameter int N = STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_ok,
  input  logic         cfg_stb,
  input  logic         adv_stb,
  input  logic         sync_to_done,
  input  logic         done_sense,
  output logic [N-1:0] stage_q
);
  logic [N-1:1] stage_gate;

  for (genvar k = 1; k < N; k++) begin : g_gate
    if (k == SYNC_STAGE) begin : g_sync
      assign stage_gate[k] = !sync_to_done || done_sense;
    end else begin : g_free
      assign stage_gate[k] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else begin
      if (cfg_stb && start_ok) stage_q[0] <= 1'b1;
      for (int k = 1; k < N; k++)
        if (adv_stb && stage_q[k-1] && stage_gate[k]) stage_q[k] <= 1'b1;
    end
  end

  assert_q0_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage_q[0]) |-> $past(start_ok && cfg_stb));
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q & $past(stage_q)) == $past(stage_q));
  assert_sync_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stage_q[SYNC_STAGE]) && $past(sync_to_done)) |-> $past(done_sense));
endmodule

// File: rtl/wake_event_tap.sv
module wake_event_tap
  import wake_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tap_sel_t          sel,
  input  logic [STAGES-1:0] stage_q,
  output logic              evt
);
  logic hit;
  logic held_q;

  assign hit = stage_q[tap_to_stage(sel)];
  assign evt = hit || held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_q <= 1'b0;
    else if (hit) held_q <= 1'b1;
  end

  assert_evt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(evt));
  assert_evt_on_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt) |-> stage_q[tap_to_stage(sel)]);
endmodule

// File: rtl/wake_sequencer.sv
module wake_sequencer
  import wake_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_stb,
  input  logic             usr_stb,
  input  logic             init_hi,
  input  logic             mem_full,
  input  logic [CNT_W-1:0] len_value,
  input  logic             use_user_clk,
  input  logic             sync_to_done,
  input  logic [1:0]       done_tap,
  input  logic [1:0]       io_tap,
  input  logic [1:0]       gsr_tap,
  input  logic             done_sense,
  output logic             done_drive_low,
  output logic             io_active,
  output logic             gsr_released,
  output logic [4:0]       stage_q
);
  logic count_match;
  logic start_ok;
  logic adv_stb;
  logic done_evt;

  assign start_ok = mem_full && count_match;
  assign adv_stb  = use_user_clk ? usr_stb : cfg_stb;

  wake_len_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .init_hi(init_hi), .cfg_stb(cfg_stb),
    .len_value(len_value), .count_match(count_match));

  wake_stage_chain #(.N(STAGES)) u_chain (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .cfg_stb(cfg_stb),
    .adv_stb(adv_stb), .sync_to_done(sync_to_done), .done_sense(done_sense),
    .stage_q(stage_q));

  wake_event_tap u_done (.clk(clk), .rst_n(rst_n), .sel(done_tap),
    .stage_q(stage_q), .evt(done_evt));
  wake_event_tap u_io   (.clk(clk), .rst_n(rst_n), .sel(io_tap),
    .stage_q(stage_q), .evt(io_active));
  wake_event_tap u_gsr  (.clk(clk), .rst_n(rst_n), .sel(gsr_tap),
    .stage_q(stage_q), .evt(gsr_released));

  assign done_drive_low = !done_evt;

  assert_user_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (use_user_clk && !usr_stb) |=> stage_q[4:1] == $past(stage_q[4:1]));
  assert_no_stage_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> stage_q == '0);
endmodule

// File: tb/wake_sequencer_bench.sv
`timescale 1ns/1ps
module wake_sequencer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_stb = 1'b0, usr_stb = 1'b0, init_hi = 1'b0, mem_full = 1'b0;
  logic [23:0] len_value = '0;
  logic use_user_clk = 1'b0, sync_to_done = 1'b0;
  logic [1:0] done_tap = 2'd0, io_tap = 2'd1, gsr_tap = 2'd2;
  logic ext_ok = 1'b1;
  logic done_sense;
  logic done_drive_low, io_active, gsr_released;
  logic [4:0] stage_q;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  // wire-AND of this device's pin and the other devices on the line
  assign done_sense = ext_ok && !done_drive_low;

  wake_sequencer u_wake_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .usr_stb(usr_stb),
    .init_hi(init_hi), .mem_full(mem_full), .len_value(len_value),
    .use_user_clk(use_user_clk), .sync_to_done(sync_to_done),
    .done_tap(done_tap), .io_tap(io_tap), .gsr_tap(gsr_tap),
    .done_sense(done_sense), .done_drive_low(done_drive_low),
    .io_active(io_active), .gsr_released(gsr_released), .stage_q(stage_q));

  // vectors: length, sync, user clock, taps, hold edge, expected first edges
  localparam int NV = 6;
  localparam int V_LEN  [NV] = '{5, 0, 3, 2, 7, 4};
  localparam int V_SYNC [NV] = '{0, 0, 1, 1, 0, 1};
  localparam int V_USR  [NV] = '{0, 1, 0, 0, 0, 1};
  localparam int V_TD   [NV] = '{0, 3, 0, 0, 1, 1};
  localparam int V_TI   [NV] = '{1, 2, 1, 3, 1, 2};
  localparam int V_TG   [NV] = '{2, 1, 2, 2, 3, 3};
  localparam int V_HOLD [NV] = '{0, 0, 12, 0, 30, 20};
  localparam int E_DONE [NV] = '{7, 5, 5, 4, 10, 7};
  localparam int E_IO   [NV] = '{8, 4, 6, 7, 10, 21};
  localparam int E_GSR  [NV] = '{9, 3, 13, 6, 12, 22};

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; init_hi = 1'b0; mem_full = 1'b0; cfg_stb = 1'b0; usr_stb = 1'b0;
    ext_ok = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic edge_step();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // reset state: R10, R8
    do_reset();
    check(stage_q == 5'b0, "R10 reset stages", stage_q, 0);
    check(done_drive_low == 1'b1, "R8 reset done pull-low", done_drive_low, 1);
    check(!io_active && !gsr_released, "R8 reset events", {io_active, gsr_released}, 0);

    // table walk: R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      int fd, fi, fg;
      do_reset();
      len_value = V_LEN[v]; sync_to_done = V_SYNC[v][0]; use_user_clk = V_USR[v][0];
      done_tap = V_TD[v][1:0]; io_tap = V_TI[v][1:0]; gsr_tap = V_TG[v][1:0];
      ext_ok = (V_HOLD[v] == 0);
      cfg_stb = 1'b1; usr_stb = 1'b1; mem_full = 1'b1; init_hi = 1'b1;
      fd = -1; fi = -1; fg = -1;
      for (int e = 1; e <= 40; e++) begin
        edge_step();
        if (e == V_HOLD[v]) ext_ok = 1'b1;
        if (!done_drive_low && fd < 0) fd = e;
        if (io_active && fi < 0) fi = e;
        if (gsr_released && fg < 0) fg = e;
      end
      check(fd == E_DONE[v], "R4/R5/R6/R7 done release edge", fd, E_DONE[v]);
      check(fi == E_IO[v],   "R4/R5/R6/R7 io active edge", fi, E_IO[v]);
      check(fg == E_GSR[v],  "R3/R4/R6 gsr release edge", fg, E_GSR[v]);
    end

    // R8: events stay active after init and mem_full drop
    init_hi = 1'b0; mem_full = 1'b0;
    repeat (5) edge_step();
    check(!done_drive_low && io_active && gsr_released, "R8 events sticky",
          {done_drive_low, io_active, gsr_released}, 3'b011);

    // R2 and R1 saturation: memory not full while count matched
    do_reset();
    len_value = 2; sync_to_done = 1'b0; use_user_clk = 1'b0;
    done_tap = 2'd0; io_tap = 2'd1; gsr_tap = 2'd2;
    cfg_stb = 1'b1; init_hi = 1'b1;
    repeat (10) edge_step();
    check(stage_q == 5'b0, "R2 no start without mem_full", stage_q, 0);
    mem_full = 1'b1;
    check(stage_q[0] == 1'b0, "R2 stage0 not before edge", stage_q[0], 0);
    edge_step();
    check(stage_q[0] == 1'b1, "R1 R2 count held at length, stage0 set", stage_q[0], 1);

    // R1: init low clears the count
    do_reset();
    len_value = 6; cfg_stb = 1'b1; mem_full = 1'b1; init_hi = 1'b1;
    repeat (4) edge_step();
    init_hi = 1'b0;
    edge_step();
    init_hi = 1'b1;
    repeat (6) edge_step();
    check(stage_q[0] == 1'b0, "R1 count restarted after init low", stage_q[0], 0);
    edge_step();
    check(stage_q[0] == 1'b1, "R1 stage0 after restarted count", stage_q[0], 1);

    // R2: only cfg strobes count
    do_reset();
    len_value = 3; mem_full = 1'b1; init_hi = 1'b1;
    for (int e = 0; e < 6; e++) begin
      cfg_stb = e[0];
      edge_step();
    end
    cfg_stb = 1'b0;
    check(stage_q[0] == 1'b0, "R2 three strobes reach length only", stage_q[0], 0);
    cfg_stb = 1'b1;
    edge_step();
    check(stage_q[0] == 1'b1, "R2 stage0 on next cfg strobe", stage_q[0], 1);

    // R9 and R3: user clock selected but absent
    do_reset();
    len_value = 1; use_user_clk = 1'b1; sync_to_done = 1'b0;
    done_tap = 2'd0; io_tap = 2'd1; gsr_tap = 2'd2;
    cfg_stb = 1'b1; usr_stb = 1'b0; mem_full = 1'b1; init_hi = 1'b1;
    repeat (30) edge_step();
    check(stage_q == 5'b00001, "R3 R9 stall after stage0", stage_q, 1);
    check(done_drive_low == 1'b1, "R9 done held before user strobe", done_drive_low, 1);
    usr_stb = 1'b1;
    edge_step();
    usr_stb = 1'b0;
    check(done_drive_low == 1'b0, "R9 done released by one user strobe", done_drive_low, 0);
    repeat (30) edge_step();
    check(io_active == 1'b0, "R9 io never active", io_active, 0);
    check(gsr_released == 1'b0, "R9 gsr never released", gsr_released, 0);
    check(stage_q == 5'b00011, "R3 cfg strobes do not advance", stage_q, 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule